// File: doc/BRIEF.md
# Sleep and CPU Clock-Speed Power Controller

This block manages power for a small microcontroller-style chip. Software reaches it over a simple register read/write bus. A power-control register holds a sleep bit. Setting that bit puts the chip into its one low-power state. A speed register slows the CPU by issuing a single-cycle CPU clock-enable pulse once every N reference cycles. The reference clock itself is left running, so peripheral timing does not change when the CPU is slowed.

While asleep, the block does the following:
- It holds the CPU by keeping the CPU clock enable low.
- It drops the enables for the crystal output, the PLL, the booster and the USB transceiver.
- It forces the external memory address pins to zero.
- It freezes the GPIO direction and output values at what they were just before sleep.

A wake mask picks which of eight wake inputs may end sleep. When sleep ends, the crystal and PLL enables return at once. The CPU clock enable, the booster enable and the transceiver enable return only after a fixed settle count of reference cycles, which gives the PLL time to lock.

Top module: `pwrSleepCtl`

## Requirements
- R1: After reset, the power-control, speed and wake-mask registers all read as zero, the chip is awake, and the CPU clock enable is high on every cycle (divide by 1).
- R2: A bus write to address 0xC00A with bit 1 set enters sleep from the next clock. A write with bit 1 clear leaves sleep. A read of 0xC00A returns the live sleep state in bit 1 and zeros in all other bits.
- R3: The speed register at 0xC008 takes a code in bits 2:0. Code 0 divides by 1, code 1 by 2 and code 4 by 16. A valid write restarts the divider, and the first enable pulse comes N cycles after the write edge.
- R4: A reserved speed code (2, 3, 5, 6 or 7) is ignored. The divider keeps its rate, and reads of 0xC008 return the last valid code.
- R5: While asleep, the memory address output is all zeros. While awake, it follows the CPU address input.
- R6: While asleep, the GPIO direction and value outputs hold the values the inputs had on the last awake cycle, whatever the inputs do.
- R7: While asleep, the crystal-output, PLL, booster, transceiver and CPU clock enables are all low.
- R8: The wake mask at 0xC00C occupies bits 7:0, one bit per wake input. While asleep, any wake input that is high and has its mask bit set clears the sleep bit at the next edge. Inputs whose mask bit is clear have no effect.
- R9: When sleep ends, the crystal and PLL enables are high from the first awake cycle. The CPU clock, booster and transceiver enables stay low for SETTLE cycles (default 16) and then resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 16 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data (combinational, zero when not reading) |
| wakeIn | input | 8 | Wake request inputs |
| cpuAddr | input | 16 | Address from the CPU to external memory |
| memAddr | output | 16 | External memory address pins |
| gpioDirIn | input | 16 | GPIO direction from the GPIO block |
| gpioValIn | input | 16 | GPIO output value from the GPIO block |
| gpioDirOut | output | 16 | GPIO direction to the pads |
| gpioValOut | output | 16 | GPIO value to the pads |
| cpuClkEn | output | 1 | Single-cycle CPU clock-enable pulse |
| xtalOutEn | output | 1 | Crystal output enable |
| pllEn | output | 1 | PLL enable |
| boosterEn | output | 1 | Booster enable |
| xcvrEn | output | 1 | USB transceiver enable |

## Verification
The divider is tried at each of the three valid rates and after a reserved code. This separates correct rate selection from a divider that either ignores writes or accepts reserved codes.

Sleep is entered while the CPU address and GPIO inputs change on every cycle. This shows whether the address pins are truly forced to zero and whether the GPIO pads hold their pre-sleep values rather than tracking the inputs.

Wake requests are applied first on a masked input and then on an enabled one. The bench counts the cycles between wake and the first CPU pulse, which catches both a missing settle delay and an off-by-one count.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  localparam int CODE_W = 3;
  localparam int DIV_W  = 5;

  localparam logic [CODE_W-1:0] SPD_FULL = 3'd0;
  localparam logic [CODE_W-1:0] SPD_HALF = 3'd1;
  localparam logic [CODE_W-1:0] SPD_SLOW = 3'd4;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrSpeed;
    logic wrMask;
    logic sleeping;
    logic cpuRun;
  } ctlStrobe_t;

  // Divide ratio for a speed code; zero marks a reserved code
  function automatic logic [DIV_W-1:0] codeToDiv(input logic [CODE_W-1:0] code);
    case (code)
      SPD_FULL: return DIV_W'(1);
      SPD_HALF: return DIV_W'(2);
      SPD_SLOW: return DIV_W'(16);
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/pwrSleepCtl_ctrl.sv
module pwrSleepCtl_ctrl
  import pwr_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter logic [AW-1:0] PWR_ADDR  = 'hC00A,
  parameter logic [AW-1:0] SPD_ADDR  = 'hC008,
  parameter logic [AW-1:0] MASK_ADDR = 'hC00C,
  parameter int SLEEP_BIT = 1,
  parameter int SETTLE    = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWr,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  input  logic          wakeHit,
  output ctlStrobe_t    strb
);

  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] SETTLE_V = CNT_W'(SETTLE);

  logic             sleepBit;
  logic             sleepNext;
  logic [CNT_W-1:0] settleCnt;
  logic             pwrWrite;

  assign pwrWrite = busWr && (busAddr == PWR_ADDR);

  // Bus write sets or clears sleep; an enabled wake overrides it
  always_comb begin
    sleepNext = sleepBit;
    if (pwrWrite) sleepNext = busWdata[SLEEP_BIT];
    if (sleepBit && wakeHit) sleepNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepBit  <= 1'b0;
      settleCnt <= '0;
    end else begin
      sleepBit <= sleepNext;
      if (sleepBit && !sleepNext)
        settleCnt <= SETTLE_V;
      else if (!sleepBit && settleCnt != '0)
        settleCnt <= settleCnt - CNT_W'(1);
    end
  end

  assign strb.wrSpeed  = busWr && (busAddr == SPD_ADDR);
  assign strb.wrMask   = busWr && (busAddr == MASK_ADDR);
  assign strb.sleeping = sleepBit;
  assign strb.cpuRun   = !sleepBit && (settleCnt == '0);

  AST_WAKE_ENDS_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    sleepBit && wakeHit |=> !sleepBit); // R8

  AST_WRITE_ENTERS_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    pwrWrite && busWdata[SLEEP_BIT] && !sleepBit |=> sleepBit); // R2

  AST_SETTLE_HOLDS_CPU: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepBit) |-> !strb.cpuRun); // R9

endmodule

// File: rtl/pwrSleepCtl_dp.sv
module pwrSleepCtl_dp
  import pwr_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int MEM_AW    = 16,
  parameter int GPIO_W    = 16,
  parameter int WAKE_W    = 8,
  parameter logic [AW-1:0] PWR_ADDR  = 'hC00A,
  parameter logic [AW-1:0] SPD_ADDR  = 'hC008,
  parameter logic [AW-1:0] MASK_ADDR = 'hC00C,
  parameter int SLEEP_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              busRd,
  input  logic [AW-1:0]     busAddr,
  input  logic [DW-1:0]     busWdata,
  output logic [DW-1:0]     busRdata,
  input  logic [WAKE_W-1:0] wakeIn,
  output logic              wakeHit,
  input  logic [MEM_AW-1:0] cpuAddr,
  output logic [MEM_AW-1:0] memAddr,
  input  logic [GPIO_W-1:0] gpioDirIn,
  input  logic [GPIO_W-1:0] gpioValIn,
  output logic [GPIO_W-1:0] gpioDirOut,
  output logic [GPIO_W-1:0] gpioValOut,
  output logic              cpuClkEn
);

  logic [CODE_W-1:0] speedCode;
  logic [DIV_W-1:0]  divN;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  newDiv;
  logic [WAKE_W-1:0] maskReg;
  logic [GPIO_W-1:0] dirHold;
  logic [GPIO_W-1:0] valHold;
  logic              lastTick;

  assign newDiv = codeToDiv(busWdata[CODE_W-1:0]);

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      speedCode <= SPD_FULL;
      divN      <= DIV_W'(1);
      maskReg   <= '0;
    end else begin
      if (strb.wrSpeed && newDiv != '0) begin
        speedCode <= busWdata[CODE_W-1:0];
        divN      <= newDiv;
      end
      if (strb.wrMask) maskReg <= busWdata[WAKE_W-1:0];
    end
  end

  // CPU clock-enable divider, one pulse per divN cycles
  assign lastTick = (divCnt == divN - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      divCnt <= '0;
    else if (!strb.cpuRun)
      divCnt <= '0;
    else if (strb.wrSpeed && newDiv != '0)
      divCnt <= '0;
    else if (lastTick)
      divCnt <= '0;
    else
      divCnt <= divCnt + DIV_W'(1);
  end

  assign cpuClkEn = strb.cpuRun && lastTick;
  assign wakeHit  = |(wakeIn & maskReg);
  assign memAddr  = strb.sleeping ? '0 : cpuAddr;

  // GPIO freeze, one cell per pad
  for (genvar g = 0; g < GPIO_W; g++) begin : gHold
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirHold[g] <= 1'b0;
        valHold[g] <= 1'b0;
      end else if (!strb.sleeping) begin
        dirHold[g] <= gpioDirIn[g];
        valHold[g] <= gpioValIn[g];
      end
    end
    assign gpioDirOut[g] = strb.sleeping ? dirHold[g] : gpioDirIn[g];
    assign gpioValOut[g] = strb.sleeping ? valHold[g] : gpioValIn[g];
  end

  // Read mux
  always_comb begin
    busRdata = '0;
    if (busRd) begin
      case (busAddr)
        PWR_ADDR:  busRdata[SLEEP_BIT]     = strb.sleeping;
        SPD_ADDR:  busRdata[CODE_W-1:0]    = speedCode;
        MASK_ADDR: busRdata[WAKE_W-1:0]    = maskReg;
        default:   busRdata                = '0;
      endcase
    end
  end

  AST_RESERVED_KEEPS_RATE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSpeed && newDiv == '0 |=> $stable(speedCode) && $stable(divN)); // R4

  AST_GPIO_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    strb.sleeping && $past(strb.sleeping) |-> $stable(gpioDirOut) && $stable(gpioValOut)); // R6

  AST_NO_CPU_IN_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.sleeping |-> !cpuClkEn); // R7

endmodule

// File: rtl/pwrSleepCtl.sv
module pwrSleepCtl
  import pwr_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int MEM_AW    = 16,
  parameter int GPIO_W    = 16,
  parameter int WAKE_W    = 8,
  parameter logic [AW-1:0] PWR_ADDR  = 'hC00A,
  parameter logic [AW-1:0] SPD_ADDR  = 'hC008,
  parameter logic [AW-1:0] MASK_ADDR = 'hC00C,
  parameter int SLEEP_BIT = 1,
  parameter int SETTLE    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [AW-1:0]     busAddr,
  input  logic [DW-1:0]     busWdata,
  output logic [DW-1:0]     busRdata,
  input  logic [WAKE_W-1:0] wakeIn,
  input  logic [MEM_AW-1:0] cpuAddr,
  output logic [MEM_AW-1:0] memAddr,
  input  logic [GPIO_W-1:0] gpioDirIn,
  input  logic [GPIO_W-1:0] gpioValIn,
  output logic [GPIO_W-1:0] gpioDirOut,
  output logic [GPIO_W-1:0] gpioValOut,
  output logic              cpuClkEn,
  output logic              xtalOutEn,
  output logic              pllEn,
  output logic              boosterEn,
  output logic              xcvrEn
);

  ctlStrobe_t strb;
  logic       wakeHit;

  pwrSleepCtl_ctrl #(
    .AW(AW), .DW(DW), .PWR_ADDR(PWR_ADDR), .SPD_ADDR(SPD_ADDR),
    .MASK_ADDR(MASK_ADDR), .SLEEP_BIT(SLEEP_BIT), .SETTLE(SETTLE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .wakeHit(wakeHit), .strb(strb)
  );

  pwrSleepCtl_dp #(
    .AW(AW), .DW(DW), .MEM_AW(MEM_AW), .GPIO_W(GPIO_W), .WAKE_W(WAKE_W),
    .PWR_ADDR(PWR_ADDR), .SPD_ADDR(SPD_ADDR), .MASK_ADDR(MASK_ADDR),
    .SLEEP_BIT(SLEEP_BIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .wakeIn(wakeIn),
    .wakeHit(wakeHit), .cpuAddr(cpuAddr), .memAddr(memAddr),
    .gpioDirIn(gpioDirIn), .gpioValIn(gpioValIn), .gpioDirOut(gpioDirOut),
    .gpioValOut(gpioValOut), .cpuClkEn(cpuClkEn)
  );

  // Oscillator and PLL return first; booster and transceiver wait for settle
  assign xtalOutEn = !strb.sleeping;
  assign pllEn     = !strb.sleeping;
  assign boosterEn = strb.cpuRun;
  assign xcvrEn    = strb.cpuRun;

  AST_PLL_BEFORE_CPU: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.sleeping) |-> pllEn && !cpuClkEn && !xcvrEn); // R9

endmodule

// File: tb/pwrSleepCtl_test.sv
module pwrSleepCtl_test;

  localparam logic [15:0] PWR  = 16'hC00A;
  localparam logic [15:0] SPD  = 16'hC008;
  localparam logic [15:0] MSK  = 16'hC00C;
  localparam int SETTLE = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [15:0] busAddr = '0, busWdata = '0, busRdata;
  logic [7:0]  wakeIn = '0;
  logic [15:0] cpuAddr = 16'h1234, memAddr;
  logic [15:0] gpioDirIn = 16'h00F0, gpioValIn = 16'hA5A5;
  logic [15:0] gpioDirOut, gpioValOut;
  logic cpuClkEn, xtalOutEn, pllEn, boosterEn, xcvrEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwrSleepCtl uut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .wakeIn(wakeIn),
    .cpuAddr(cpuAddr), .memAddr(memAddr), .gpioDirIn(gpioDirIn),
    .gpioValIn(gpioValIn), .gpioDirOut(gpioDirOut), .gpioValOut(gpioValOut),
    .cpuClkEn(cpuClkEn), .xtalOutEn(xtalOutEn), .pllEn(pllEn),
    .boosterEn(boosterEn), .xcvrEn(xcvrEn)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          mSleep;
  int          mSettle, mDiv, mCnt;
  logic [2:0]  mCode;
  logic [7:0]  mMask;
  logic [15:0] mHoldDir, mHoldVal;

  function automatic int divOf(input logic [2:0] c);
    if (c == 3'd0) return 1;
    if (c == 3'd1) return 2;
    if (c == 3'd4) return 16;
    return 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSleep = 0; mSettle = 0; mDiv = 1; mCnt = 0; mCode = 0; mMask = 0;
      mHoldDir = 0; mHoldVal = 0;
    end else begin
      bit ns, run, vw;
      ns = mSleep;
      if (busWr && busAddr == PWR) ns = busWdata[1];
      if (mSleep && ((wakeIn & mMask) != 0)) ns = 0;
      run = !mSleep && mSettle == 0;
      vw  = busWr && busAddr == SPD && divOf(busWdata[2:0]) != 0;
      if (!run || vw || mCnt == mDiv - 1) mCnt = 0;
      else mCnt = mCnt + 1;
      if (vw) begin mCode = busWdata[2:0]; mDiv = divOf(busWdata[2:0]); end
      if (busWr && busAddr == MSK) mMask = busWdata[7:0];
      if (!mSleep) begin mHoldDir = gpioDirIn; mHoldVal = gpioValIn; end
      if (mSleep && !ns) mSettle = SETTLE;
      else if (!mSleep && mSettle > 0) mSettle = mSettle - 1;
      mSleep = ns;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit run;
      logic [15:0] eRd;
      run = !mSleep && mSettle == 0;
      eRd = 0;
      if (busRd) begin
        if (busAddr == PWR) eRd[1] = mSleep;
        else if (busAddr == SPD) eRd[2:0] = mCode;
        else if (busAddr == MSK) eRd[7:0] = mMask;
      end
      chk(cpuClkEn == (run && mCnt == mDiv - 1), "R3 cpuClkEn", cpuClkEn, run && mCnt == mDiv - 1);
      chk(pllEn == !mSleep && xtalOutEn == !mSleep, "R7 pll/xtal", {pllEn, xtalOutEn}, {!mSleep, !mSleep});
      chk(boosterEn == run && xcvrEn == run, "R9 booster/xcvr", {boosterEn, xcvrEn}, {run, run});
      chk(memAddr == (mSleep ? 16'h0 : cpuAddr), "R5 memAddr", memAddr, mSleep ? 16'h0 : cpuAddr);
      chk(gpioDirOut == (mSleep ? mHoldDir : gpioDirIn) && gpioValOut == (mSleep ? mHoldVal : gpioValIn),
          "R6 gpio", {gpioDirOut, gpioValOut},
          {(mSleep ? mHoldDir : gpioDirIn), (mSleep ? mHoldVal : gpioValIn)});
      chk(busRdata == eRd, "R2 read data", busRdata, eRd);
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    forever begin
      @(negedge clk); #1;
      cpuAddr   = cpuAddr + 16'h1357;
      gpioDirIn = gpioDirIn ^ 16'h0F1E;
      gpioValIn = gpioValIn + 16'h0203;
    end
  end

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); #1;
    busWr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    busRd = 1; busAddr = a; #1;
    d = busRdata;
    busRd = 0;
  endtask

  task automatic countPulses(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      if (cpuClkEn) cnt++;
    end
  endtask

  initial begin
    logic [15:0] v;
    logic [15:0] frozenDir, frozenVal;
    int n;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;

    // R1 reset state
    rd(PWR, v); chk(v == 0, "R1 power reg reset", v, 0);
    rd(SPD, v); chk(v == 0, "R1 speed reg reset", v, 0);
    rd(MSK, v); chk(v == 0, "R1 mask reg reset", v, 0);
    countPulses(8, n); chk(n == 8, "R1 full speed after reset", n, 8);

    // R3 divide ratios
    wr(SPD, 16'd1); countPulses(32, n); chk(n == 16, "R3 divide by 2", n, 16);
    wr(SPD, 16'd4); countPulses(64, n); chk(n == 4, "R3 divide by 16", n, 4);

    // R4 reserved code ignored
    wr(SPD, 16'd5); rd(SPD, v); chk(v == 4, "R4 reserved code readback", v, 4);
    countPulses(64, n); chk(n == 4, "R4 rate kept after reserved code", n, 4);
    wr(SPD, 16'd0); countPulses(8, n); chk(n == 8, "R3 back to divide by 1", n, 8);

    // R2 / R5 / R6 / R7 sleep entry
    wr(MSK, 16'h0005);
    rd(MSK, v); chk(v == 16'h0005, "R8 mask readback", v, 5);
    wr(PWR, 16'h0002);
    rd(PWR, v); chk(v == 16'h0002, "R2 sleep bit reads back", v, 2);
    chk({pllEn, xtalOutEn, boosterEn, xcvrEn, cpuClkEn} == 0, "R7 enables low in sleep",
        {pllEn, xtalOutEn, boosterEn, xcvrEn, cpuClkEn}, 0);
    chk(memAddr == 0 && cpuAddr != 0, "R5 address pins low", memAddr, 0);
    frozenDir = gpioDirOut; frozenVal = gpioValOut;
    repeat (6) @(negedge clk);
    chk(gpioDirOut == frozenDir && gpioValOut == frozenVal, "R6 gpio frozen",
        {gpioDirOut, gpioValOut}, {frozenDir, frozenVal});

    // R8 masked wake ignored
    @(negedge clk); #1; wakeIn = 8'h02;
    repeat (5) @(negedge clk);
    chk(pllEn == 0 && cpuClkEn == 0, "R8 masked wake ignored", pllEn, 0);
    rd(PWR, v); chk(v == 16'h0002, "R8 still asleep after masked wake", v, 2);

    // R8 / R9 enabled wake and settle
    @(negedge clk); #1; wakeIn = 8'h04;
    @(negedge clk); #1; wakeIn = 8'h00;
    chk(pllEn == 1 && xtalOutEn == 1, "R9 pll back first", {pllEn, xtalOutEn}, 2'b11);
    chk(cpuClkEn == 0 && boosterEn == 0, "R9 cpu held during settle", cpuClkEn, 0);
    rd(PWR, v); chk(v == 0, "R8 wake cleared sleep bit", v, 0);
    n = 0;
    while (!cpuClkEn && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(n == SETTLE, "R9 settle length", n, SETTLE);

    // R2 bus write leaves sleep; sleep at slow speed
    wr(SPD, 16'd4);
    wr(PWR, 16'h0002);
    repeat (4) @(negedge clk);
    chk(cpuClkEn == 0 && memAddr == 0, "R7 asleep at slow speed", cpuClkEn, 0);
    wr(PWR, 16'h0000);
    rd(PWR, v); chk(v == 0, "R2 write clears sleep", v, 0);
    repeat (SETTLE + 40) @(negedge clk);
    countPulses(64, n); chk(n == 4, "R3 slow rate after wake", n, 4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule